// File: doc/BRIEF.md
# Blinking Pixel Modifier Stage

This block is one pipeline stage of a display raster engine. Each cycle it accepts one 24-bit pixel together with a per-pixel blink flag. When the flag is set and the global blink phase is active, the pixel is rewritten by one of several selectable operations: bitwise OR or XOR with a mask word, substitution by an offset word, a whole-word add of the offset, a per-colour-byte add of the offset, a halving dim, or a saturating brighten. Any other pixel passes through unchanged.

The rewritten value leaves one clock later. When the colour lookup table is enabled it is presented as the table index. Otherwise it goes straight to the colour multiplexer output. A valid bit and a table-select bit travel with the data. The lookup table memory and the multiplexer sit outside this block.

Top module: `blink_pixel_stage`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs are cleared to zero on that edge.
- R2: Latency is exactly one cycle. `out_valid`, `out_lut_sel` and the data outputs at edge N+1 reflect the inputs sampled at edge N, and `out_valid` equals the sampled `in_valid`.
- R3: A pixel is modified only when `in_blink` and `blink_phase` are both 1. Otherwise the output value equals `in_pixel` whatever the mode.
- R4: Mode 4'b0010 produces `in_pixel | mask_word`.
- R5: Mode 4'b0011 produces `in_pixel ^ mask_word`.
- R6: Mode 4'b0100 produces `offset_word`.
- R7: Mode 4'b0101 produces `(in_pixel + offset_word) mod 2^24`.
- R8: Mode 4'b0110 adds each offset byte (bits 23:16, 15:8 and 7:0) to the matching pixel byte modulo 256, with no carry between bytes.
- R9: Mode 4'b1100 produces `in_pixel >> 1`: the LSB is dropped and the MSB becomes 0.
- R10: Mode 4'b1101 produces `in_pixel + 1`, saturating at 24'hFFFFFF.
- R11: Codes 4'b0000, 4'b0001, 4'b0111 through 4'b1011, 4'b1110 and 4'b1111 leave the pixel unchanged.
- R12: When the sampled `lut_en` is 1, `out_lut_sel` is 1, `out_lut_index` carries the value and `out_mux_pixel` is 0. When it is 0, `out_lut_sel` is 0, `out_mux_pixel` carries the value and `out_lut_index` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input pixel is valid |
| in_pixel | input | 24 | Incoming pixel |
| in_blink | input | 1 | Pixel is marked as blinking |
| blink_phase | input | 1 | Blink phase is currently active |
| blink_mode | input | 4 | Blink operation code |
| mask_word | input | 24 | Mask operand for OR and XOR |
| offset_word | input | 24 | Operand for replace and add modes |
| lut_en | input | 1 | Route the result to the lookup table |
| out_valid | output | 1 | Output pixel valid |
| out_lut_sel | output | 1 | Result is on the table index |
| out_lut_index | output | 24 | Table index (0 when bypassed) |
| out_mux_pixel | output | 24 | Direct pixel to colour mux (0 when indexed) |

## Verification
Every result is due at the first rising edge after its inputs are driven. Back-to-back vectors therefore show up on consecutive edges. The driver changes inputs on falling edges and pushes the expected output, computed from the requirements, into a queue. The monitor pops one entry 1 ns after each rising edge that follows a push, so each comparison lands in the cycle the one-cycle latency predicts. Reset is checked on the falling edge after a reset edge, and the queue must be empty once the stream has drained.

// File: rtl/blink_pkg.sv
// Package: blink operation codes shared by the pixel stage and its units.
// Assumes a 4-bit mode field. Codes not listed here select pass-through.
package blink_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        BM_OR        = 4'b0010,
        BM_XOR       = 4'b0011,
        BM_REPLACE   = 4'b0100,
        BM_ADD_WHOLE = 4'b0101,
        BM_ADD_RGB   = 4'b0110,
        BM_DIM       = 4'b1100,
        BM_BRIGHT    = 4'b1101
    } blink_mode_e;
endpackage

// File: rtl/blink_alu.sv
// Module: blink_alu
// Combinational pixel rewrite for one blink operation.
// Assumes PIX_W is a whole multiple of CH_W.
// Returns the pixel unchanged when 'active' is low or the code is unused.
module blink_alu
    import blink_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int CH_W  = 8
) (
    input  logic [PIX_W-1:0]  pixel,
    input  logic              active,
    input  logic [MODE_W-1:0] mode,
    input  logic [PIX_W-1:0]  mask,
    input  logic [PIX_W-1:0]  offset,
    output logic [PIX_W-1:0]  result
);
    localparam int NCH = PIX_W / CH_W;

    logic [PIX_W-1:0] rgb_sum;
    logic [PIX_W:0]   inc_ext;
    logic [PIX_W-1:0] bright_val;

    // Per-channel add: each byte wraps on its own, with no carry into the next.
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        assign rgb_sum[c*CH_W +: CH_W] = pixel[c*CH_W +: CH_W] + offset[c*CH_W +: CH_W];
    end

    // Saturating increment for the bright mode.
    always_comb begin
        inc_ext    = {1'b0, pixel} + (PIX_W+1)'(1);
        bright_val = inc_ext[PIX_W] ? {PIX_W{1'b1}} : inc_ext[PIX_W-1:0];
    end

    // Pick the operation from the mode code; pass through when inactive.
    always_comb begin
        result = pixel;
        if (active) begin
            case (mode)
                BM_OR:        result = pixel | mask;
                BM_XOR:       result = pixel ^ mask;
                BM_REPLACE:   result = offset;
                BM_ADD_WHOLE: result = pixel + offset;
                BM_ADD_RGB:   result = rgb_sum;
                BM_DIM:       result = {1'b0, pixel[PIX_W-1:1]};
                BM_BRIGHT:    result = bright_val;
                default:      result = pixel;
            endcase
        end
    end
endmodule

// File: rtl/blink_out_reg.sv
// Module: blink_out_reg
// Output register: captures the rewritten pixel and steers it either to
// the lookup-table index or to the direct colour-mux path.
// Assumes a synchronous active-low reset. The unused path is held at zero.
module blink_out_reg #(
    parameter int PIX_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_d,
    input  logic             lut_en_d,
    input  logic [PIX_W-1:0] value_d,
    output logic             valid_q,
    output logic             lut_sel_q,
    output logic [PIX_W-1:0] index_q,
    output logic [PIX_W-1:0] mux_q
);
    // Register the valid bit, the route bit and the steered data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            lut_sel_q <= 1'b0;
            index_q   <= '0;
            mux_q     <= '0;
        end else begin
            valid_q   <= valid_d;
            lut_sel_q <= lut_en_d;
            index_q   <= lut_en_d ? value_d : '0;
            mux_q     <= lut_en_d ? '0 : value_d;
        end
    end

    // The path that is not selected stays at zero.
    AST_IDLE_PATH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lut_sel_q ? (mux_q == '0) : (index_q == '0)); // R12
endmodule

// File: rtl/blink_pixel_stage.sv
// Module: blink_pixel_stage
// One pipeline stage of the raster engine: applies the selected blink
// operation to flagged pixels during the active phase, then registers the
// result towards the lookup table or the colour mux. Fixed one-cycle latency.
// Assumes synchronous active-low reset and operands that are stable for the
// cycle in which they are sampled.
module blink_pixel_stage
    import blink_pkg::*;
#(
    parameter int PIX_W = 24,
    parameter int CH_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [PIX_W-1:0]  in_pixel,
    input  logic              in_blink,
    input  logic              blink_phase,
    input  logic [MODE_W-1:0] blink_mode,
    input  logic [PIX_W-1:0]  mask_word,
    input  logic [PIX_W-1:0]  offset_word,
    input  logic              lut_en,
    output logic              out_valid,
    output logic              out_lut_sel,
    output logic [PIX_W-1:0]  out_lut_index,
    output logic [PIX_W-1:0]  out_mux_pixel
);
    logic             blink_active;
    logic [PIX_W-1:0] new_pixel;
    logic [PIX_W-1:0] out_value;

    // A pixel is rewritten only if it is flagged and the phase is on.
    assign blink_active = in_blink & blink_phase;

    blink_alu #(.PIX_W(PIX_W), .CH_W(CH_W)) u_alu (
        .pixel  (in_pixel),
        .active (blink_active),
        .mode   (blink_mode),
        .mask   (mask_word),
        .offset (offset_word),
        .result (new_pixel)
    );

    blink_out_reg #(.PIX_W(PIX_W)) u_oreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_d   (in_valid),
        .lut_en_d  (lut_en),
        .value_d   (new_pixel),
        .valid_q   (out_valid),
        .lut_sel_q (out_lut_sel),
        .index_q   (out_lut_index),
        .mux_q     (out_mux_pixel)
    );

    // Whichever path is live, seen at the ports.
    assign out_value = out_lut_sel ? out_lut_index : out_mux_pixel;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid))); // R2
    AST_ROUTE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_lut_sel == $past(lut_en))); // R12
    AST_NO_BLINK_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !blink_active |=> (out_value == $past(in_pixel))); // R3
    AST_DIM_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_active && blink_mode == BM_DIM) |=> (out_value[PIX_W-1] == 1'b0)); // R9
    AST_BRIGHT_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (blink_active && blink_mode == BM_BRIGHT) |=> (out_value >= $past(in_pixel))); // R10
endmodule

// File: tb/test_blink_pixel_stage.sv
// Scoreboard bench: a driver pushes expected results, a monitor pops them.
module test_blink_pixel_stage;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [23:0] in_pixel = '0;
    logic        in_blink = 1'b0;
    logic        blink_phase = 1'b0;
    logic [3:0]  blink_mode = '0;
    logic [23:0] mask_word = '0;
    logic [23:0] offset_word = '0;
    logic        lut_en = 1'b0;
    logic        out_valid;
    logic        out_lut_sel;
    logic [23:0] out_lut_index;
    logic [23:0] out_mux_pixel;

    typedef struct {
        logic        v;
        logic        sel;
        logic [23:0] idx;
        logic [23:0] mux;
        string       tag;
    } exp_t;

    exp_t sb[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;

    always #2.5 clk = ~clk;

    blink_pixel_stage i_blink_pixel_stage (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pixel(in_pixel),
        .in_blink(in_blink), .blink_phase(blink_phase), .blink_mode(blink_mode),
        .mask_word(mask_word), .offset_word(offset_word), .lut_en(lut_en),
        .out_valid(out_valid), .out_lut_sel(out_lut_sel),
        .out_lut_index(out_lut_index), .out_mux_pixel(out_mux_pixel)
    );

    // Reference value, built from the requirement text.
    function automatic logic [23:0] ref_value(logic [23:0] p, logic bl, logic ph,
                                             logic [3:0] m, logic [23:0] mk, logic [23:0] of);
        logic [23:0] r;
        r = p;
        if (bl && ph) begin
            case (m)
                4'b0010: r = p | mk;
                4'b0011: r = p ^ mk;
                4'b0100: r = of;
                4'b0101: r = p + of;
                4'b0110: begin
                    r[23:16] = p[23:16] + of[23:16];
                    r[15:8]  = p[15:8]  + of[15:8];
                    r[7:0]   = p[7:0]   + of[7:0];
                end
                4'b1100: r = p / 2;
                4'b1101: r = (p == 24'hFFFFFF) ? p : p + 24'd1;
                default: r = p;
            endcase
        end
        return r;
    endfunction

    // Drive one vector on a falling edge and queue its expected result.
    task automatic drive(logic v, logic [23:0] p, logic bl, logic ph, logic [3:0] m,
                         logic le, string tag);
        exp_t e;
        logic [23:0] val;
        @(negedge clk);
        in_valid = v; in_pixel = p; in_blink = bl; blink_phase = ph;
        blink_mode = m; lut_en = le;
        val   = ref_value(p, bl, ph, m, mask_word, offset_word);
        e.v   = v;
        e.sel = le;
        e.idx = le ? val : 24'h0;
        e.mux = le ? 24'h0 : val;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: one result is due at each rising edge after a push.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_checks++;
                if (out_valid !== e.v || out_lut_sel !== e.sel ||
                    out_lut_index !== e.idx || out_mux_pixel !== e.mux) begin
                    n_fails++;
                    $display("FAIL %s: got v=%b sel=%b idx=%h mux=%h, expected v=%b sel=%b idx=%h mux=%h",
                             e.tag, out_valid, out_lut_sel, out_lut_index, out_mux_pixel,
                             e.v, e.sel, e.idx, e.mux);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs clear under reset, even while in_valid is asserted.
        in_valid = 1'b1; in_pixel = 24'hABCDEF; lut_en = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_lut_sel !== 1'b0 || out_lut_index !== 24'h0 || out_mux_pixel !== 24'h0) begin
            n_fails++;
            $display("FAIL R1: got v=%b sel=%b idx=%h mux=%h, expected all zero",
                     out_valid, out_lut_sel, out_lut_index, out_mux_pixel);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;

        mask_word   = 24'h0F00F0;
        offset_word = 24'h020304;

        // R3: blinking inactive (flag or phase low) leaves pixel intact.
        drive(1, 24'h123456, 1, 0, 4'b0010, 0, "R3 phase off");
        drive(1, 24'h123456, 0, 1, 4'b0011, 0, "R3 flag off");
        // R4 / R5 / R6 back to back, which also exercises R2 pipelining.
        drive(1, 24'h123456, 1, 1, 4'b0010, 0, "R4 or");
        drive(1, 24'h123456, 1, 1, 4'b0011, 0, "R5 xor");
        drive(1, 24'h123456, 1, 1, 4'b0100, 0, "R6 replace");
        // R7: whole-word add, with a wrap case.
        drive(1, 24'h100000, 1, 1, 4'b0101, 0, "R7 add");
        drive(1, 24'hFFFFFF, 1, 1, 4'b0101, 0, "R7 add wrap");
        // R8: per-byte add, byte overflow must not carry.
        drive(1, 24'h10FF20, 1, 1, 4'b0110, 0, "R8 rgb add");
        drive(1, 24'hFEFFFD, 1, 1, 4'b0110, 0, "R8 rgb wrap");
        // R9: dim.
        drive(1, 24'hFFFFFF, 1, 1, 4'b1100, 0, "R9 dim max");
        drive(1, 24'h800001, 1, 1, 4'b1100, 0, "R9 dim");
        // R10: bright, normal and saturated.
        drive(1, 24'h00FFFF, 1, 1, 4'b1101, 0, "R10 bright");
        drive(1, 24'hFFFFFF, 1, 1, 4'b1101, 0, "R10 bright sat");
        // R11: unused and zero codes leave pixel intact.
        drive(1, 24'h5A5A5A, 1, 1, 4'b0000, 0, "R11 code0");
        drive(1, 24'h5A5A5A, 1, 1, 4'b0001, 0, "R11 code1");
        drive(1, 24'h5A5A5A, 1, 1, 4'b0111, 0, "R11 code7");
        drive(1, 24'h5A5A5A, 1, 1, 4'b1011, 0, "R11 code11");
        drive(1, 24'h5A5A5A, 1, 1, 4'b1111, 0, "R11 code15");
        // R12: routing to the lookup-table index.
        drive(1, 24'h123456, 1, 1, 4'b0011, 1, "R12 lut xor");
        drive(1, 24'h0000FE, 1, 1, 4'b0110, 1, "R12 lut rgb");
        drive(1, 24'h777777, 0, 0, 4'b0100, 1, "R12 lut pass");
        drive(1, 24'h777777, 1, 1, 4'b0100, 0, "R12 back to mux");
        // R2: valid drop is reported exactly one cycle later.
        drive(0, 24'h111111, 1, 1, 4'b0010, 0, "R2 invalid");
        drive(1, 24'h222222, 1, 1, 4'b1100, 1, "R2 valid again");

        // New operands mid-stream.
        mask_word   = 24'hFFFFFF;
        offset_word = 24'h7F8001;
        drive(1, 24'h00FF00, 1, 1, 4'b0011, 0, "R5 full mask");
        drive(1, 24'h81807F, 1, 1, 4'b0110, 0, "R8 mixed bytes");
        drive(1, 24'hFFFFFF, 1, 1, 4'b0101, 1, "R7 wrap lut");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        n_checks++;
        if (sb.size() != 0) begin
            n_fails++;
            $display("FAIL R2: got %0d pending results, expected 0", sb.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule